// File: doc/BRIEF.md
# Prescaled Timer with Clear-on-Compare

This block is a 16-bit up-counter whose advance is gated by a selectable tick source. A 3-bit select input picks one of several sources: no ticks at all, a tick every system clock, a tick from one of four taps of a shared free-running divider (every 8, 64, 256 or 1024 clocks), or a tick from a rising or falling edge of an external count pin. The external pin is brought into the clock domain through a synchroniser and an edge detector before it is used.

A compare value and a clear enable set the wrap point. When clearing is enabled and the counter equals the compare value on a tick, the next tick does not increment. It loads zero instead, so the compare value is held for one full tick period before the wrap. When clearing is disabled, a match changes nothing and the counter rolls over naturally from 0xFFFF to 0x0000. A registered flag pulses for one clock whenever a tick finds the counter equal to the compare value.

Top module: `presc_timer`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `count_o` is 0 and `match_o` is 0.
- R2: With `clk_sel_i` = 3'b000, `count_o` does not change, whatever happens on `ext_pin_i`.
- R3: With `clk_sel_i` = 3'b001, `count_o` increases by one on every clock edge, unless a clear applies.
- R4: With `clk_sel_i` = 3'b010, 3'b011, 3'b100 or 3'b101, `count_o` advances exactly once in every window of 8, 64, 256 or 1024 consecutive clock edges respectively.
- R5: With `clk_sel_i` = 3'b110, `count_o` advances once for each falling edge of `ext_pin_i` and ignores rising edges. The advance appears on the third clock edge after the pin changes.
- R6: With `clk_sel_i` = 3'b111, `count_o` advances once for each rising edge of `ext_pin_i` and ignores falling edges, with the same latency as R5.
- R7: With `clr_on_match_i` = 1 and one tick per clock, the counter for compare value C runs ... C-1, C, 0, 1 ..., giving a period of C+1.
- R8: With `clr_on_match_i` = 0, a tick at count C moves the counter to C+1.
- R9: `match_o` is high for the one clock following a tick on which `count_o` equaled `cmp_a_i`, and is low otherwise.
- R10: With `clr_on_match_i` = 0, the counter rolls from 0xFFFF to 0x0000 on the next tick.
- R11: With the divide-by-8 source and clearing on, every value, including C and the 0 that follows it, is held for exactly 8 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel_i | input | 3 | Tick source select (encodings in R2 to R6) |
| clr_on_match_i | input | 1 | When 1, the tick after a compare match loads zero |
| cmp_a_i | input | 16 | Compare value |
| ext_pin_i | input | 1 | External count pin (asynchronous) |
| count_o | output | 16 | Current counter value |
| match_o | output | 1 | One-clock compare-match pulse |

## Verification
Two situations are hard to reach from the ports. The first is the natural rollover at 0xFFFF, which the bench reaches with an uninterrupted run of 65536 system-clock ticks. The second is the divider phase, which the ports never show. The bench avoids depending on that phase: it measures advances over windows that are whole multiples of the divide ratio. For the clear-on-compare test with the divide-by-8 source, it first waits for the first change of the counter. It then checks that each value holds for seven samples and changes on the eighth.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    CS_STOP     = 3'b000,
    CS_SYS      = 3'b001,
    CS_DIV8     = 3'b010,
    CS_DIV64    = 3'b011,
    CS_DIV256   = 3'b100,
    CS_DIV1024  = 3'b101,
    CS_EXT_FALL = 3'b110,
    CS_EXT_RISE = 3'b111
  } clk_sel_e;

  localparam int NUM_TAPS = 4;
  // log2 of each divider tap, lowest ratio first
  localparam int TAP_LOG2 [NUM_TAPS] = '{3, 6, 8, 10};
  localparam int DIV_W = 10;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic                clk,
  input  logic                rst,
  output logic [NUM_TAPS-1:0] tap_tick_o
);
  logic [W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int SH = TAP_LOG2[g];
    assign tap_tick_o[g] = &div_q[SH-1:0];
  end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
  end

  assign rise_o =  sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign fall_o = ~sh_q[SYNC_STAGES-1] &  sh_q[SYNC_STAGES];

  // R6
  ext_rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
  // R5
  ext_fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             clr_en_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic hit;
  assign hit = (cnt_o == cmp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o   <= '0;
      match_o <= 1'b0;
    end else begin
      match_o <= tick_i & hit;
      if (tick_i) begin
        if (clr_en_i && hit) cnt_o <= '0;
        else                 cnt_o <= cnt_o + 1'b1;
      end
    end
  end

  // R7
  clr_after_match_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && clr_en_i && cnt_o == cmp_i) |=> (cnt_o == '0));
  // R8
  no_clr_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !clr_en_i && cnt_o == cmp_i) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));
  // R9
  match_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cnt_o == cmp_i) |=> match_o);
  // R9
  match_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(tick_i && cnt_o == cmp_i) |=> !match_o);
endmodule

// File: rtl/presc_timer.sv
module presc_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       clk_sel_i,
  input  logic             clr_on_match_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic             ext_pin_i,
  output logic [CNT_W-1:0] count_o,
  output logic             match_o
);
  logic [NUM_TAPS-1:0] taps;
  logic                ext_rise, ext_fall, tick;

  tmr_prescaler #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .tap_tick_o(taps)
  );

  tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(ext_pin_i), .rise_o(ext_rise), .fall_o(ext_fall)
  );

  always_comb begin
    case (clk_sel_e'(clk_sel_i))
      CS_STOP:     tick = 1'b0;
      CS_SYS:      tick = 1'b1;
      CS_DIV8:     tick = taps[0];
      CS_DIV64:    tick = taps[1];
      CS_DIV256:   tick = taps[2];
      CS_DIV1024:  tick = taps[3];
      CS_EXT_FALL: tick = ext_fall;
      CS_EXT_RISE: tick = ext_rise;
      default:     tick = 1'b0;
    endcase
  end

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick_i(tick), .clr_en_i(clr_on_match_i),
    .cmp_i(cmp_a_i), .cnt_o(count_o), .match_o(match_o)
  );

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_sel_i == 3'b000) |=> (count_o == $past(count_o)));
  // R3
  sys_step_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_sel_i == 3'b001 && !(clr_on_match_i && count_o == cmp_a_i))
      |=> (count_o == CNT_W'($past(count_o) + 1'b1)));
  // R10
  wrap_top_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_sel_i == 3'b001 && !clr_on_match_i && count_o == '1) |=> (count_o == '0));
endmodule

// File: tb/test_presc_timer.sv
module test_presc_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       clk_sel = 3'b000;
  logic             clr_en = 1'b0;
  logic [CNT_W-1:0] cmp = '0;
  logic             pin = 1'b0;
  logic [CNT_W-1:0] count;
  logic             match;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  presc_timer i_presc_timer (
    .clk(clk), .rst(rst), .clk_sel_i(clk_sel), .clr_on_match_i(clr_en),
    .cmp_a_i(cmp), .ext_pin_i(pin), .count_o(count), .match_o(match)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; clk_sel = 3'b000; clr_en = 1'b0; cmp = '0; pin = 1'b0;
    step(3);
    chk(count == 0 && match == 0, "R1", {count, 15'b0, match}, 0);
    rst = 1'b0;
    step(1);
    chk(count == 0 && match == 0, "R1", {count, 15'b0, match}, 0);
  endtask

  task automatic pulse(input int hi, input int lo);
    pin = 1'b1; step(hi);
    pin = 1'b0; step(lo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2: stopped source ignores clocks and pin edges
    step(20);
    chk(count == 0, "R2", count, 0);
    pulse(6, 6);
    chk(count == 0, "R2", count, 0);

    // R3: one step per clock
    clk_sel = 3'b001;
    for (int i = 1; i <= 50; i++) begin
      step(1);
      chk(count == i, "R3", count, i);
    end
    clk_sel = 3'b000;
    step(10);
    chk(count == 50, "R2", count, 50);

    // R4: exactly one advance per window of the divide ratio
    for (int s = 2; s <= 5; s++) begin
      automatic int lg = (s == 2) ? 3 : (s == 3) ? 6 : (s == 4) ? 8 : 10;
      automatic int d = 1 << lg;
      do_reset();
      clk_sel = 3'(s);
      for (int k = 1; k <= 4; k++) begin
        step(d);
        chk(count == k, "R4", count, k);
      end
    end

    // R11: divide-by-8 with clear, every value held 8 clocks
    do_reset();
    cmp = 16'd3; clr_en = 1'b1; clk_sel = 3'b010;
    for (int i = 0; i < 20 && count == 0; i++) step(1);
    chk(count == 1, "R11", count, 1);
    for (int k = 0; k < 8; k++) begin
      automatic int prev = (k + 1) % 4;
      automatic int nxt = (k + 2) % 4;
      step(7);
      chk(count == prev, "R11", count, prev);
      step(1);
      chk(count == nxt, "R11", count, nxt);
    end

    // R7 / R9: clear at compare, system clock
    do_reset();
    cmp = 16'd5; clr_en = 1'b1; clk_sel = 3'b001;
    for (int i = 1; i <= 20; i++) begin
      step(1);
      chk(count == i % 6, "R7", count, i % 6);
      chk(match == (i % 6 == 0), "R9", match, (i % 6 == 0));
    end

    // R8 / R9: match passes through without clear
    do_reset();
    cmp = 16'd5; clr_en = 1'b0; clk_sel = 3'b001;
    for (int i = 1; i <= 20; i++) begin
      step(1);
      chk(count == i, "R8", count, i);
      chk(match == (i == 6), "R9", match, (i == 6));
    end

    // R10: natural rollover
    do_reset();
    cmp = 16'd5; clk_sel = 3'b001;
    step(65535);
    chk(count == 16'hFFFF, "R10", count, 16'hFFFF);
    step(1);
    chk(count == 0, "R10", count, 0);
    chk(match == 0, "R10", match, 0);
    step(1);
    chk(count == 1, "R10", count, 1);

    // R6: rising edges only
    do_reset();
    clk_sel = 3'b111;
    for (int k = 1; k <= 5; k++) begin
      pin = 1'b1; step(2);
      chk(count == k - 1, "R6", count, k - 1);
      step(1);
      chk(count == k, "R6", count, k);
      step(3);
      pin = 1'b0; step(6);
      chk(count == k, "R6", count, k);
    end

    // R5: falling edges only
    do_reset();
    clk_sel = 3'b110;
    for (int k = 1; k <= 5; k++) begin
      pin = 1'b1; step(6);
      chk(count == k - 1, "R5", count, k - 1);
      pin = 1'b0; step(2);
      chk(count == k - 1, "R5", count, k - 1);
      step(1);
      chk(count == k, "R5", count, k);
      step(3);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule